// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

The engine moves an incoming byte stream into memory buffers chosen by a ring of receive descriptors. The descriptors and buffers sit in a small on-chip RAM model. Each descriptor takes two 32-bit words. The word at offset 0 carries a 16-bit status field in bits 31:16 and a 16-bit length field in bits 15:0. The word at offset 4 carries the buffer's byte address. In the status field, bit 15 marks the descriptor empty (owned by the engine), bit 13 marks it as the last descriptor of the ring, bit 11 marks the buffer that ends a packet, and bit 2 flags a packet error.

Software fills the RAM through a word-wide host port. It sets the ring base in 8-byte descriptor units and the maximum buffer size in 4-byte units, loads the current-descriptor pointer, and then enables reception. The engine opens the pointed descriptor on the first byte that arrives while it is idle. It places bytes little-endian from the buffer address and closes the descriptor in the cycle after the closing byte. A descriptor closes when the buffer is full, at end of packet, or on an abort. After a close the pointer moves to the next descriptor, or returns to the base when the closed descriptor carries the ring-end bit.

Top module: `rxd_ring_engine`

## Requirements
- R1: In reset, and on the first cycle after reset, `cur_ptr` is 0 and `desc_done` and `rx_busy` are low.
- R2: After a close, `cur_ptr` advances by 8. If the closed descriptor has status bit 13 set, `cur_ptr` instead reloads 8 times `cfg_base_slot`.
- R3: A buffer never receives more than 4 times `cfg_maxlen_w` bytes. A buffer that reaches that count closes with length equal to the maximum and status bit 11 clear. The rest of the packet continues in the next descriptor.
- R4: A byte with `in_last` set closes the open buffer. The length field becomes the number of bytes stored, bit 11 is set and bit 15 is cleared. All other status bits keep their values.
- R5: An `in_abort` pulse while a buffer is open closes it with bits 2 and 11 set and the length equal to the bytes stored so far. With no buffer open, `in_abort` changes neither memory nor `cur_ptr`.
- R6: While a buffer is open, `cur_ptr` names the descriptor being filled, and `desc_done` reports that descriptor. While idle, `cur_ptr` names the next descriptor to fill.
- R7: A write on `cfg_ptr_we` loads `cur_ptr` with 8 times `cfg_ptr_slot` only when no buffer is open. A write while a buffer is open is ignored.
- R8: A byte that arrives while idle, with bit 15 of the pointed descriptor clear, is discarded. `rx_busy` pulses in the following cycle and `cur_ptr` is unchanged. A later byte opens the descriptor once bit 15 is set.
- R9: While `rx_en` is low, incoming bytes change neither memory nor `cur_ptr`.
- R10: Byte n of a buffer goes to byte address buffer+n, in lane (buffer+n) mod 4 of its 32-bit word, with lane 0 in bits 7:0. Other lanes of the word keep their contents.
- R11: `desc_done` is high for exactly one cycle, in the cycle after the byte or abort that closes a descriptor. Bytes arrive at most every other cycle.
- R12: When the byte that fills the buffer also has `in_last` set, only that descriptor closes. It closes with bit 11 set and the full length, and no further descriptor is opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| cfg_base_slot | input | 13 | Ring base in 8-byte descriptor units |
| cfg_maxlen_w | input | 14 | Maximum buffer size in 4-byte units |
| cfg_ptr_we | input | 1 | Pointer load strobe |
| cfg_ptr_slot | input | 13 | Pointer load value in descriptor units |
| in_valid | input | 1 | Byte strobe |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Byte ends the packet |
| in_abort | input | 1 | Packet error, ends the open buffer |
| mem_we | input | 1 | Host word write |
| mem_waddr | input | 14 | Host word address (byte address / 4) |
| mem_wdata | input | 32 | Host write data |
| mem_rdata | output | 32 | Host read data, combinational |
| cur_ptr | output | 16 | Current descriptor byte offset |
| desc_done | output | 1 | A descriptor is being closed |
| rx_busy | output | 1 | Byte dropped for lack of a free descriptor |

## Verification
The byte that fills a buffer can also be the last byte of its packet, so the buffer-full close and the end-of-packet close fall on the same edge. The bench provokes this with a packet exactly as long as the maximum buffer. The close must carry bit 11 with the full length, and the scoreboard must see exactly one close. The next descriptor must stay untouched with `cur_ptr` parked on it. A second overlap is a pointer load issued while a buffer is open: `cur_ptr` must not move until the ordinary close.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int ST_EMPTY = 15;
  localparam int ST_RING_END = 13;
  localparam int ST_PKT_END = 11;
  localparam int ST_PKT_ERR = 2;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_FILL  = 2'd1,
    FS_CLOSE = 2'd2
  } fill_st_e;
endpackage

// File: rtl/rxd_ram.sv
module rxd_ram #(
  parameter int DEPTH = 1024,
  parameter int HW    = 14
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [HW-1:0] a_addr,
  input  logic [31:0]   a_wdata,
  output logic [31:0]   a_rdata,
  input  logic          b_we,
  input  logic [3:0]    b_be,
  input  logic [29:0]   b_addr,
  input  logic [31:0]   b_wdata,
  input  logic [HW-1:0] s_addr,
  output logic [15:0]   s_stat,
  input  logic [HW-1:0] p_addr,
  output logic [31:0]   p_rdata
);
  localparam int IW = $clog2(DEPTH);

  logic [31:0] mem [DEPTH];
  logic        a_ok, b_ok, s_ok, p_ok;

  assign a_ok = (a_addr < HW'(DEPTH));
  assign b_ok = (b_addr < 30'(DEPTH));
  assign s_ok = (s_addr < HW'(DEPTH));
  assign p_ok = (p_addr < HW'(DEPTH));

  assign a_rdata = a_ok ? mem[a_addr[IW-1:0]] : '0;
  assign s_stat  = s_ok ? mem[s_addr[IW-1:0]][31:16] : '0;
  assign p_rdata = p_ok ? mem[p_addr[IW-1:0]] : '0;

  // Host word writes first; engine lane writes override on the same word.
  always_ff @(posedge clk) begin
    if (a_we && a_ok) begin
      mem[a_addr[IW-1:0]] <= a_wdata;
    end
    for (int ln = 0; ln < 4; ln++) begin
      if (b_we && b_ok && b_be[ln]) begin
        mem[b_addr[IW-1:0]][ln*8 +: 8] <= b_wdata[ln*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/rxd_ptr.sv
module rxd_ptr #(
  parameter int SW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] base_slot,
  input  logic          sw_we,
  input  logic [SW-1:0] sw_slot,
  input  logic          busy_open,
  input  logic          adv,
  input  logic          wrap,
  output logic [SW-1:0] slot_o
);
  logic [SW-1:0] slot_q, slot_n;
  logic          slot_en;

  always_comb begin
    slot_en = 1'b0;
    slot_n  = slot_q;
    if (adv) begin
      slot_en = 1'b1;
      slot_n  = wrap ? base_slot : slot_q + SW'(1);
    end else if (sw_we && !busy_open) begin
      slot_en = 1'b1;
      slot_n  = sw_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (slot_en) begin
      slot_q <= slot_n;
    end
  end

  assign slot_o = slot_q;

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    adv && wrap |=> slot_q == $past(base_slot)); // R2
  AST_STEP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wrap |=> slot_q == $past(slot_q) + SW'(1)); // R2
  AST_PTR_HOLD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_open && !adv |=> $stable(slot_q)); // R7
endmodule

// File: rtl/rxd_fill_ctl.sv
module rxd_fill_ctl
  import rxd_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int HW    = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic [LEN_W-1:0] maxlen,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             in_abort,
  input  logic [HW-1:0]    desc_waddr,
  input  logic [15:0]      desc_stat,
  input  logic [31:0]      desc_buf,
  output logic             wr_en,
  output logic [3:0]       wr_be,
  output logic [29:0]      wr_word,
  output logic [31:0]      wr_data,
  output logic             open_o,
  output logic             adv_o,
  output logic             wrap_o,
  output logic             done_o,
  output logic             busy_o
);
  fill_st_e         st_q, st_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic [31:0]      bufa_q, bufa_n;
  logic             last_q, last_n;
  logic             err_q, err_n;
  logic             busy_q, busy_n;
  logic             beat, take;
  logic [31:0]      base_addr, byte_addr;
  logic [LEN_W-1:0] base_cnt, cnt_inc;
  logic [15:0]      stat_new;

  assign beat      = in_valid && rx_en;
  assign base_addr = (st_q == FS_IDLE) ? desc_buf : bufa_q;
  assign base_cnt  = (st_q == FS_IDLE) ? '0 : cnt_q;
  assign byte_addr = base_addr + 32'(base_cnt);
  assign cnt_inc   = base_cnt + LEN_W'(1);

  always_comb begin
    stat_new = desc_stat;
    stat_new[ST_EMPTY] = 1'b0;
    if (last_q) stat_new[ST_PKT_END] = 1'b1;
    if (err_q)  stat_new[ST_PKT_ERR] = 1'b1;
  end

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    bufa_n  = bufa_q;
    last_n  = last_q;
    err_n   = err_q;
    busy_n  = 1'b0;
    take    = 1'b0;
    wr_en   = 1'b0;
    wr_be   = '0;
    wr_word = '0;
    wr_data = '0;
    adv_o   = 1'b0;
    wrap_o  = 1'b0;
    unique case (st_q)
      FS_IDLE: begin
        if (beat) begin
          if (desc_stat[ST_EMPTY]) take = 1'b1;
          else busy_n = 1'b1;
        end
      end
      FS_FILL: begin
        if (in_abort) begin
          st_n   = FS_CLOSE;
          last_n = 1'b1;
          err_n  = 1'b1;
        end else if (beat) begin
          take = 1'b1;
        end
      end
      FS_CLOSE: begin
        wr_en   = 1'b1;
        wr_be   = 4'hF;
        wr_word = 30'(desc_waddr);
        wr_data = {stat_new, 16'(cnt_q)};
        adv_o   = 1'b1;
        wrap_o  = desc_stat[ST_RING_END];
        st_n    = FS_IDLE;
        last_n  = 1'b0;
        err_n   = 1'b0;
      end
      default: st_n = FS_IDLE;
    endcase
    if (take) begin
      wr_en   = 1'b1;
      wr_be   = 4'b0001 << byte_addr[1:0];
      wr_word = byte_addr[31:2];
      wr_data = {4{in_data}};
      cnt_n   = cnt_inc;
      bufa_n  = base_addr;
      if (in_last || (cnt_inc >= maxlen)) begin
        st_n   = FS_CLOSE;
        last_n = in_last;
      end else begin
        st_n = FS_FILL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      cnt_q  <= '0;
      bufa_q <= '0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      busy_q <= busy_n;
      last_q <= last_n;
      err_q  <= err_n;
      if (take) begin
        cnt_q  <= cnt_n;
        bufa_q <= bufa_n;
      end
    end
  end

  assign open_o = (st_q != FS_IDLE);
  assign done_o = (st_q == FS_CLOSE);
  assign busy_o = busy_q;

  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != FS_IDLE |-> cnt_q <= maxlen); // R3
  AST_CLOSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == FS_CLOSE |=> st_q == FS_IDLE); // R11
  AST_BEAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !in_valid); // R11
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> $past(!wr_en)); // R8
endmodule

// File: rtl/rxd_ring_engine.sv
module rxd_ring_engine #(
  parameter int DEPTH = 1024,
  parameter int PTR_W = 16,
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en,
  input  logic [PTR_W-4:0]   cfg_base_slot,
  input  logic [LEN_W-3:0]   cfg_maxlen_w,
  input  logic               cfg_ptr_we,
  input  logic [PTR_W-4:0]   cfg_ptr_slot,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  input  logic               in_last,
  input  logic               in_abort,
  input  logic               mem_we,
  input  logic [PTR_W-3:0]   mem_waddr,
  input  logic [31:0]        mem_wdata,
  output logic [31:0]        mem_rdata,
  output logic [PTR_W-1:0]   cur_ptr,
  output logic               desc_done,
  output logic               rx_busy
);
  localparam int SW = PTR_W - 3;
  localparam int HW = PTR_W - 2;

  logic [SW-1:0]    slot;
  logic [LEN_W-1:0] maxlen;
  logic [15:0]      d_stat;
  logic [31:0]      d_buf;
  logic             e_we;
  logic [3:0]       e_be;
  logic [29:0]      e_word;
  logic [31:0]      e_data;
  logic             is_open, adv, wrap;

  assign maxlen  = {cfg_maxlen_w, 2'b00};
  assign cur_ptr = {slot, 3'b000};

  rxd_ram #(.DEPTH(DEPTH), .HW(HW)) u_ram (
    .clk     (clk),
    .a_we    (mem_we),
    .a_addr  (mem_waddr),
    .a_wdata (mem_wdata),
    .a_rdata (mem_rdata),
    .b_we    (e_we),
    .b_be    (e_be),
    .b_addr  (e_word),
    .b_wdata (e_data),
    .s_addr  ({slot, 1'b0}),
    .s_stat  (d_stat),
    .p_addr  ({slot, 1'b1}),
    .p_rdata (d_buf)
  );

  rxd_fill_ctl #(.LEN_W(LEN_W), .HW(HW)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .maxlen     (maxlen),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_last    (in_last),
    .in_abort   (in_abort),
    .desc_waddr ({slot, 1'b0}),
    .desc_stat  (d_stat),
    .desc_buf   (d_buf),
    .wr_en      (e_we),
    .wr_be      (e_be),
    .wr_word    (e_word),
    .wr_data    (e_data),
    .open_o     (is_open),
    .adv_o      (adv),
    .wrap_o     (wrap),
    .done_o     (desc_done),
    .busy_o     (rx_busy)
  );

  rxd_ptr #(.SW(SW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_slot (cfg_base_slot),
    .sw_we     (cfg_ptr_we),
    .sw_slot   (cfg_ptr_slot),
    .busy_open (is_open),
    .adv       (adv),
    .wrap      (wrap),
    .slot_o    (slot)
  );

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_done && rx_busy)); // R8
endmodule

// File: tb/tb_rxd_ring_engine.sv
module tb_rxd_ring_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic [12:0] cfg_base_slot = '0;
  logic [13:0] cfg_maxlen_w = '0;
  logic        cfg_ptr_we = 1'b0;
  logic [12:0] cfg_ptr_slot = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_abort = 1'b0;
  logic        mem_we = 1'b0;
  logic [13:0] mem_waddr = '0;
  logic [31:0] mem_wdata = '0;
  logic [31:0] mem_rdata;
  logic [15:0] cur_ptr;
  logic        desc_done;
  logic        rx_busy;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  logic        busy_seen;

  always #4 clk = ~clk;

  rxd_ring_engine dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .cfg_base_slot(cfg_base_slot), .cfg_maxlen_w(cfg_maxlen_w),
    .cfg_ptr_we(cfg_ptr_we), .cfg_ptr_slot(cfg_ptr_slot),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_abort(in_abort),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cur_ptr(cur_ptr), .desc_done(desc_done), .rx_busy(rx_busy)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected descriptor offset on every close.
  always @(negedge clk) begin
    if (rst_n && desc_done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected close", {16'h0, cur_ptr}, 32'hFFFF_FFFF);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(cur_ptr == e, "R6 close reports filled descriptor", {16'h0, cur_ptr}, {16'h0, e});
      end
    end
  end

  task automatic host_wr(input logic [15:0] baddr, input logic [31:0] d);
    @(negedge clk);
    mem_we = 1'b1; mem_waddr = baddr[15:2]; mem_wdata = d;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  task automatic host_chk(input logic [15:0] baddr, input logic [31:0] exp, input string req);
    @(negedge clk);
    mem_waddr = baddr[15:2];
    #1;
    check(mem_rdata == exp, req, mem_rdata, exp);
  endtask

  task automatic beat(input logic [7:0] d, input logic lst);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = lst;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    busy_seen = rx_busy;
  endtask

  task automatic abort_pulse();
    @(negedge clk);
    in_abort = 1'b1;
    @(negedge clk);
    in_abort = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    busy_seen = 1'b0;
    repeat (3) @(negedge clk);
    check(cur_ptr == 16'h0 && !desc_done && !rx_busy, "R1 in reset", {16'h0, cur_ptr}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cur_ptr == 16'h0 && !desc_done && !rx_busy, "R1 after reset", {16'h0, cur_ptr}, 32'h0);

    cfg_base_slot = 13'd8;   // base 0x40
    cfg_maxlen_w  = 14'd2;   // 8 bytes
    host_wr(16'h40, 32'h8000_0000); host_wr(16'h44, 32'h100);
    host_wr(16'h48, 32'h8000_0000); host_wr(16'h4C, 32'h120);
    host_wr(16'h50, 32'hA000_0000); host_wr(16'h54, 32'h140);
    for (int i = 0; i < 4; i++) host_wr(16'h100 + 16'(i*4), 32'h0);
    for (int i = 0; i < 4; i++) host_wr(16'h120 + 16'(i*4), 32'h0);
    for (int i = 0; i < 4; i++) host_wr(16'h140 + 16'(i*4), 32'h0);

    // R7: pointer load while idle
    @(negedge clk); cfg_ptr_we = 1'b1; cfg_ptr_slot = 13'd8;
    @(negedge clk); cfg_ptr_we = 1'b0;
    check(cur_ptr == 16'h40, "R7 load while idle", {16'h0, cur_ptr}, 32'h40);
    rx_en = 1'b1;

    // Packet A: 3 bytes
    exp_q.push_back(16'h40);
    beat(8'h11, 1'b0);
    check(cur_ptr == 16'h40, "R6 pointer names open descriptor", {16'h0, cur_ptr}, 32'h40);
    beat(8'h22, 1'b0);
    beat(8'h33, 1'b1);
    @(negedge clk);
    host_chk(16'h40, 32'h0800_0003, "R4 end-of-packet close");
    host_chk(16'h100, 32'h0033_2211, "R10 byte lanes");
    check(cur_ptr == 16'h48, "R2 advance by 8", {16'h0, cur_ptr}, 32'h48);

    // Packet B: 10 bytes, buffer cap 8, pointer load attempted mid-buffer
    exp_q.push_back(16'h48);
    beat(8'hA0, 1'b0);
    @(negedge clk); cfg_ptr_we = 1'b1; cfg_ptr_slot = 13'd10;
    @(negedge clk); cfg_ptr_we = 1'b0;
    check(cur_ptr == 16'h48, "R7 load ignored while open", {16'h0, cur_ptr}, 32'h48);
    for (int i = 1; i < 8; i++) beat(8'hA0 + 8'(i), 1'b0);
    exp_q.push_back(16'h50);
    beat(8'hA8, 1'b0);
    beat(8'hA9, 1'b1);
    @(negedge clk);
    host_chk(16'h48, 32'h0000_0008, "R3 full close without end flag");
    host_chk(16'h120, 32'hA3A2_A1A0, "R3 buffer word 0");
    host_chk(16'h124, 32'hA7A6_A5A4, "R3 buffer word 1");
    host_chk(16'h128, 32'h0000_0000, "R3 no byte past maximum");
    host_chk(16'h50, 32'h2800_0002, "R4 ring-end bit kept");
    host_chk(16'h140, 32'h0000_A9A8, "R3 continuation in next buffer");
    check(cur_ptr == 16'h40, "R2 wrap to base", {16'h0, cur_ptr}, 32'h40);

    // R8: descriptor not empty
    beat(8'h55, 1'b1);
    check(busy_seen == 1'b1, "R8 busy pulse", {31'h0, busy_seen}, 32'h1);
    @(negedge clk);
    check(rx_busy == 1'b0, "R8 busy single cycle", {31'h0, rx_busy}, 32'h0);
    check(cur_ptr == 16'h40, "R8 pointer unchanged", {16'h0, cur_ptr}, 32'h40);
    host_chk(16'h100, 32'h0033_2211, "R8 byte discarded");

    // R9: disabled receiver
    host_wr(16'h40, 32'h8000_0000);
    rx_en = 1'b0;
    beat(8'h66, 1'b1);
    @(negedge clk);
    host_chk(16'h100, 32'h0033_2211, "R9 buffer untouched");
    host_chk(16'h40, 32'h8000_0000, "R9 descriptor untouched");
    check(cur_ptr == 16'h40, "R9 pointer unchanged", {16'h0, cur_ptr}, 32'h40);
    rx_en = 1'b1;

    // R5: abort while idle, then abort mid-buffer
    abort_pulse();
    @(negedge clk);
    host_chk(16'h40, 32'h8000_0000, "R5 idle abort ignored");
    check(cur_ptr == 16'h40, "R5 idle abort pointer", {16'h0, cur_ptr}, 32'h40);
    exp_q.push_back(16'h40);
    beat(8'h77, 1'b0);
    beat(8'h88, 1'b0);
    abort_pulse();
    @(negedge clk);
    host_chk(16'h40, 32'h0804_0002, "R5 abort close");
    host_chk(16'h100, 32'h0033_8877, "R10 partial word kept");
    check(cur_ptr == 16'h48, "R2 advance after abort", {16'h0, cur_ptr}, 32'h48);

    // R12: full and last on the same byte
    host_wr(16'h48, 32'h8000_0000);
    exp_q.push_back(16'h48);
    for (int i = 0; i < 7; i++) beat(8'hB0 + 8'(i), 1'b0);
    beat(8'hB7, 1'b1);
    repeat (3) @(negedge clk);
    host_chk(16'h48, 32'h0800_0008, "R12 coincident close");
    host_chk(16'h124, 32'hB7B6_B5B4, "R12 last word");
    host_chk(16'h50, 32'h2800_0002, "R12 next descriptor untouched");
    check(cur_ptr == 16'h50, "R12 pointer parked", {16'h0, cur_ptr}, 32'h50);

    // R10: unaligned buffer start
    host_wr(16'h50, 32'hA000_0000);
    host_wr(16'h54, 32'h142);
    exp_q.push_back(16'h50);
    beat(8'hC1, 1'b0);
    beat(8'hC2, 1'b0);
    beat(8'hC3, 1'b1);
    @(negedge clk);
    host_chk(16'h140, 32'hC2C1_A9A8, "R10 upper lanes");
    host_chk(16'h144, 32'h0000_00C3, "R10 next word lane 0");
    host_chk(16'h50, 32'h2800_0003, "R4 length of unaligned buffer");
    check(cur_ptr == 16'h40, "R2 second wrap", {16'h0, cur_ptr}, 32'h40);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 all expected closes seen", exp_q.size(), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule